// File: doc/BRIEF.md
# Microframe Index Counter

This block keeps the 14-bit microframe index of a USB host controller. A periodic tick input, one pulse per 125 µs microframe, advances the index by one while the controller is running. When the index rolls over from its largest value to zero, the block can raise a single-cycle rollover event. An enable input controls whether that event is raised.

To save power, the block stops counting when every root port is in a state where no bus traffic is expected. A second enable decides which link states count as quiet. While the controller is halted, no frame activity occurs, so the index holds its value. Only in that halted state can software load a new value into the index. The index value, the rollover pulse and a flag showing that counting is active are the outputs.

Top module: `uframe_index`

## Requirements
- R1: After reset `frameIndex` is 0 and `wrapEvt` is 0.
- R2: While `countActive` is 1, each clock edge that samples `tick` high adds 1 to `frameIndex`. An edge with `tick` low leaves it unchanged.
- R3: The index is 14 bits wide. A counting tick at 0x3FFF makes the next value 0.
- R4: With `wrapEvtEn` high, a counting tick at 0x3FFF raises `wrapEvt` for exactly one cycle. That cycle is the first cycle in which `frameIndex` reads 0.
- R5: With `wrapEvtEn` low on the rollover edge, `wrapEvt` stays 0.
- R6: While `runEn` is 0 (halted), `countActive` is 0 and ticks do not change `frameIndex`.
- R7: Each port owns a 4-bit field of `portStates`: port p uses bits [4p+3:4p]. The codes are 0 active, 1 suspended (U3), 2 disconnected, 3 disabled, 4 training, 5 powered-off, and 6 to 15 other active states. With `u3StopEn` high, the quiet codes are 1, 2, 3 and 5. If every port holds a quiet code, `countActive` is 0.
- R8: With `u3StopEn` low, the quiet codes are 2, 3, 4 and 5. If every port holds a quiet code, `countActive` is 0.
- R9: When running and any port holds a non-quiet code, `countActive` is 1 in the same cycle. The next tick then counts.
- R10: A write with `wrEn` high while halted loads `wrData` at that clock edge. A write while `runEn` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle microframe tick |
| runEn | input | 1 | 1 = running, 0 = halted |
| wrapEvtEn | input | 1 | Enables the rollover event |
| u3StopEn | input | 1 | Selects the quiet-state set |
| portStates | input | 16 | Per-port 4-bit link state codes |
| wrEn | input | 1 | Software write strobe for the index |
| wrData | input | 14 | Value to load on a write |
| frameIndex | output | 14 | Current microframe index |
| wrapEvt | output | 1 | One-cycle rollover event |
| countActive | output | 1 | Counting is currently allowed |

## Verification
`countActive` is combinational, so the bench checks it 1 ns after it drives the inputs on the falling edge. `frameIndex` and `wrapEvt` each pass through one register. The bench therefore checks them on the falling edge that follows the rising edge that sampled the stimulus, against a model that was advanced at that same edge. Directed cases load 0x3FFE while halted and then tick through the rollover, once with the event enabled and once with it disabled. A seeded random run mixes ticks, halts, writes and port-state sets.

// File: rtl/uframe_pkg.sv
package uframe_pkg;
  parameter int PORT_STATE_W = 4;

  localparam logic [PORT_STATE_W-1:0] PS_U3      = 4'd1;
  localparam logic [PORT_STATE_W-1:0] PS_DISC    = 4'd2;
  localparam logic [PORT_STATE_W-1:0] PS_DISABLE = 4'd3;
  localparam logic [PORT_STATE_W-1:0] PS_TRAIN   = 4'd4;
  localparam logic [PORT_STATE_W-1:0] PS_POWOFF  = 4'd5;

  typedef struct packed {
    logic step;        // advance the index this edge
    logic load;        // load software value this edge
    logic wrapPermit;  // rollover event allowed
  } uframe_strobe_t;

  function automatic logic portQuiet(input logic [PORT_STATE_W-1:0] code,
                                     input logic u3Mode);
    logic common;
    common = (code == PS_DISC) || (code == PS_DISABLE) || (code == PS_POWOFF);
    return u3Mode ? (common || code == PS_U3) : (common || code == PS_TRAIN);
  endfunction
endpackage

// File: rtl/uframe_ctrl.sv
module uframe_ctrl
  import uframe_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick,
  input  logic                              runEn,
  input  logic                              wrapEvtEn,
  input  logic                              u3StopEn,
  input  logic [NUM_PORTS*PORT_STATE_W-1:0] portStates,
  input  logic                              wrEn,
  output logic                              countActive,
  output uframe_strobe_t                    strobe
);
  logic [NUM_PORTS-1:0] portIdle;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign portIdle[p] = portQuiet(portStates[p*PORT_STATE_W +: PORT_STATE_W], u3StopEn);
  end

  assign countActive       = runEn && !(&portIdle);
  assign strobe.step       = tick && countActive;
  assign strobe.load       = wrEn && !runEn;
  assign strobe.wrapPermit = wrapEvtEn;

  AST_HALT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |-> !countActive); // R6
  AST_ALL_QUIET_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (&portIdle) |-> !strobe.step); // R7
  AST_LOAD_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |-> !strobe.step); // R10
endmodule

// File: rtl/uframe_dp.sv
module uframe_dp
  import uframe_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  uframe_strobe_t strobe,
  input  logic [IDX_W-1:0] wrData,
  output logic [IDX_W-1:0] frameIndex,
  output logic           wrapEvt
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic atMax;
  assign atMax = (frameIndex == IDX_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frameIndex <= '0;
      wrapEvt    <= 1'b0;
    end else begin
      wrapEvt <= strobe.step && atMax && strobe.wrapPermit;
      if (strobe.load)      frameIndex <= wrData;
      else if (strobe.step) frameIndex <= frameIndex + 1'b1;
    end
  end

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrapEvt |-> (frameIndex == '0)); // R4
  AST_WRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wrapEvt |=> !wrapEvt); // R4
  AST_WRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrapPermit |=> !wrapEvt); // R5
  AST_ROLL_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && !strobe.load && atMax) |=> (frameIndex == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.step && !strobe.load) |=> $stable(frameIndex)); // R2
endmodule

// File: rtl/uframe_index.sv
module uframe_index
  import uframe_pkg::*;
#(
  parameter int IDX_W     = 14,
  parameter int NUM_PORTS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick,
  input  logic                              runEn,
  input  logic                              wrapEvtEn,
  input  logic                              u3StopEn,
  input  logic [NUM_PORTS*PORT_STATE_W-1:0] portStates,
  input  logic                              wrEn,
  input  logic [IDX_W-1:0]                  wrData,
  output logic [IDX_W-1:0]                  frameIndex,
  output logic                              wrapEvt,
  output logic                              countActive
);
  uframe_strobe_t strobe;

  uframe_ctrl #(.NUM_PORTS(NUM_PORTS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .runEn(runEn),
    .wrapEvtEn(wrapEvtEn), .u3StopEn(u3StopEn), .portStates(portStates),
    .wrEn(wrEn), .countActive(countActive), .strobe(strobe)
  );

  uframe_dp #(.IDX_W(IDX_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .frameIndex(frameIndex), .wrapEvt(wrapEvt)
  );

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && countActive && frameIndex != {IDX_W{1'b1}})
      |=> frameIndex == $past(frameIndex) + 1'b1); // R2
  AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (runEn && !tick) |=> $stable(frameIndex)); // R10
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!runEn && !wrEn) |=> $stable(frameIndex)); // R6
endmodule

// File: tb/uframe_index_tb.sv
`timescale 1ns/1ps
module uframe_index_tb_top;
  localparam int IDX_W = 14;
  localparam int NP    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, runEn = 1'b0, wrapEvtEn = 1'b0, u3StopEn = 1'b0, wrEn = 1'b0;
  logic [NP*4-1:0] portStates = '0;
  logic [IDX_W-1:0] wrData = '0;
  logic [IDX_W-1:0] frameIndex;
  logic wrapEvt, countActive;

  int vectors = 0;
  int miscompares = 0;
  logic [IDX_W-1:0] mIdx = '0;
  logic mWrap = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uframe_index #(.IDX_W(IDX_W), .NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .runEn(runEn), .wrapEvtEn(wrapEvtEn),
    .u3StopEn(u3StopEn), .portStates(portStates), .wrEn(wrEn), .wrData(wrData),
    .frameIndex(frameIndex), .wrapEvt(wrapEvt), .countActive(countActive)
  );

  function automatic bit quietCode(input logic [3:0] c, input bit u3);
    if (u3) return (c == 4'd1) || (c == 4'd2) || (c == 4'd3) || (c == 4'd5);
    return (c == 4'd2) || (c == 4'd3) || (c == 4'd4) || (c == 4'd5);
  endfunction

  function automatic bit expActive(input bit run, input logic [NP*4-1:0] ps, input bit u3);
    bit allQ = 1;
    for (int p = 0; p < NP; p++) allQ &= quietCode(ps[p*4 +: 4], u3);
    return run && !allQ;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive inputs at negedge, check combinational flag, clock, update model, check registers.
  task automatic cycle(input bit t, input bit run, input bit we, input logic [IDX_W-1:0] wd,
                       input bit wen, input bit u3, input logic [NP*4-1:0] ps, input string tag);
    bit act;
    tick = t; runEn = run; wrEn = we; wrData = wd; wrapEvtEn = wen; u3StopEn = u3; portStates = ps;
    #1;
    act = expActive(run, ps, u3);
    check({tag, " countActive (R7/R8: R9)"}, 32'(countActive), 32'(act));
    @(posedge clk);
    mWrap = 1'b0;
    if (we && !run) mIdx = wd;
    else if (t && act) begin
      mWrap = (mIdx == {IDX_W{1'b1}}) && wen;
      mIdx  = mIdx + 1'b1;
    end
    @(negedge clk);
    check({tag, " frameIndex"}, 32'(frameIndex), 32'(mIdx));
    check({tag, " wrapEvt"}, 32'(wrapEvt), 32'(mWrap));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [NP*4-1:0] busy;
    void'($urandom(32'd2024));
    busy = 16'h0000;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 frameIndex reset", 32'(frameIndex), 32'd0);
    check("R1 wrapEvt reset", 32'(wrapEvt), 32'd0);
    rst_n = 1'b1;

    // R2 counting and holding
    cycle(1, 1, 0, '0, 1, 0, busy, "R2 tick");
    cycle(0, 1, 0, '0, 1, 0, busy, "R2 no tick");
    cycle(1, 1, 0, '0, 1, 0, busy, "R2 tick2");
    // R10 write while running is ignored
    cycle(0, 1, 1, 14'h1234, 1, 0, busy, "R10 run write");
    // R6 halted: ticks ignored
    cycle(1, 0, 0, '0, 1, 0, busy, "R6 halted tick");
    // R10 write while halted, near max
    cycle(0, 0, 1, 14'h3FFE, 1, 0, busy, "R10 halted write");
    // R3 R4 rollover with event
    cycle(1, 1, 0, '0, 1, 0, busy, "R3 to max");
    cycle(1, 1, 0, '0, 1, 0, busy, "R4 rollover evt");
    cycle(0, 1, 0, '0, 1, 0, busy, "R4 one cycle");
    // R5 rollover without event
    cycle(0, 0, 1, 14'h3FFF, 0, 0, busy, "R5 load max");
    cycle(1, 1, 0, '0, 0, 0, busy, "R5 rollover no evt");
    // R7 u3 mode: all quiet in {1,2,3,5}
    cycle(1, 1, 0, '0, 1, 1, 16'h5321, "R7 quiet set");
    cycle(1, 1, 0, '0, 1, 1, 16'h5324, "R7 training busy");
    // R8 normal mode: all quiet in {2,3,4,5}
    cycle(1, 1, 0, '0, 1, 0, 16'h5432, "R8 quiet set");
    cycle(1, 1, 0, '0, 1, 0, 16'h5431, "R8 U3 busy");
    // R9 resume on next tick
    cycle(1, 1, 0, '0, 1, 0, 16'h2222, "R9 stopped");
    cycle(1, 1, 0, '0, 1, 0, 16'h2220, "R9 resume");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [NP*4-1:0] ps;
      bit u3 = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0) begin
        for (int p = 0; p < NP; p++) ps[p*4 +: 4] = 4'($urandom_range(1, 5));
      end else begin
        ps = 16'($urandom);
      end
      if ($urandom_range(0, 199) == 0) begin
        cycle(0, 0, 1, 14'h3FFD, 1, 0, 16'h0000, "R3 random preload");
      end
      cycle($urandom_range(0, 1), $urandom_range(0, 5) != 0, $urandom_range(0, 7) == 0,
            14'($urandom), $urandom_range(0, 3) != 0, u3, ps, "R2 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule